// File: doc/BRIEF.md
# Page-mode parallel memory controller

This block sits on the host side of a 32K x 8 asynchronous nonvolatile memory with active-low chip-enable, write-enable and output-enable pins. It turns single-byte read and write requests from a simple ready/valid style host port into pin-level bus cycles. All pin timing is set by clock-cycle counts given as parameters.

The address is split into a row (upper bits) and a column (lowest three bits, eight bytes per row). After an access the controller keeps chip enable low and remembers the open row. A later request to the same row is served as a column-only page access, with chip enable held low. A request to another row first raises chip enable and waits out the precharge interval, then opens the new row. A write finishes within its own bus cycle and needs no completion polling. The open row is also closed after a programmable number of idle cycles, or when the host pulses a close input.

Top module: `pmem_ctrl`

## Requirements
- R1: After reset, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe is 0, ready is 1 and rvalid is 0.
- R2: Each accepted read produces exactly one rvalid pulse whose rdata equals the byte stored at req_addr. mem_oe_n is low and the pin address is unchanged for at least T_ACC cycles before the byte is taken.
- R3: Each accepted write produces one mem_we_n low pulse of at least max(T_ACC, T_WP, T_DS) cycles. During the pulse mem_dq_oe is 1 and mem_dq_o and mem_addr are stable. mem_ce_n stays low until mem_we_n has risen, and the byte lands at req_addr.
- R4: A request whose address bits [14:3] match the open row is served with no rising edge on mem_ce_n.
- R5: A request to a different row raises mem_ce_n. mem_ce_n then stays high for at least T_PC cycles before it falls again.
- R6: mem_oe_n is never low while mem_we_n is low or mem_dq_oe is 1.
- R7: Back-to-back writes in one row each get their own mem_we_n falling edge, with mem_we_n high for at least one cycle between pulses.
- R8: With T_IDLE > 0, a row left open with no request for T_IDLE cycles is closed by raising mem_ce_n. The row is not closed before T_IDLE-1 idle cycles have passed.
- R9: A close_row pulse while a row is open and no request is presented raises mem_ce_n. A request presented together with close_row is served as a new-row cycle.
- R10: A request is accepted on a clock edge where req and ready are both 1. ready is 0 in the cycle after acceptance and stays 0 until the controller can take the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Byte address: [14:3] row, [2:0] column |
| req_wdata | input | 8 | Write byte |
| close_row | input | 1 | Request to close the open row |
| ready | output | 1 | Controller can accept a request this cycle |
| rvalid | output | 1 | One-cycle pulse: rdata holds read result |
| rdata | output | 8 | Read result |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | 15 | Memory address pins |
| mem_dq_o | output | 8 | Data to the memory pad |
| mem_dq_oe | output | 1 | Drive enable of the data pad |
| mem_dq_i | input | 8 | Data from the memory pad |

## Verification
If the open-row register or the hit compare is wrong, a same-row request shows a chip-enable rise it should not have. A wrong register can also serve a foreign row as a page access, which returns the wrong byte on the very next rvalid. A short access or precharge counter shows at once: the device model returns corrupt data for a read taken early, and it flags a short chip-enable-high or write-enable-low interval at the edge that ends it. A broken idle counter shows as chip enable still low, or already high, at the negedges on either side of the T_IDLE boundary.

// File: rtl/pmem_pkg.sv
package pmem_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_RD,
      ST_WSET,
      ST_WLOW,
      ST_HOLD
   } pm_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/pmem_timer.sv
module pmem_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pmem_row_tracker.sv
module pmem_row_tracker #(
   parameter int ROW_W  = 12,
   parameter int T_IDLE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic [ROW_W-1:0] open_row_in,
   input  logic             close,
   input  logic             hold_idle,
   input  logic [ROW_W-1:0] chk_row,
   output logic             row_open,
   output logic             hit,
   output logic             timeout
);

   logic [ROW_W-1:0] open_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open <= 1'b0;
         open_row <= '0;
      end else if (close) begin
         row_open <= 1'b0;
      end else if (open_set) begin
         row_open <= 1'b1;
         open_row <= open_row_in;
      end
   end

   assign hit = row_open && (chk_row == open_row);

   generate
      if (T_IDLE > 0) begin : g_idle
         localparam int IW = $clog2(T_IDLE + 1);
         logic [IW-1:0] idle_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idle_cnt <= '0;
            else if (!hold_idle)
               idle_cnt <= '0;
            else if (idle_cnt != IW'(T_IDLE - 1))
               idle_cnt <= idle_cnt + 1'b1;
         end

         assign timeout = hold_idle && (idle_cnt == IW'(T_IDLE - 1));
      end else begin : g_no_idle
         assign timeout = 1'b0;
      end
   endgenerate

   // R8: an idle close can only fire while a row is open
   p_timeout_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |-> row_open);

endmodule

// File: rtl/pmem_wdata_reg.sv
module pmem_wdata_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cap,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (cap)
         q <= d;
   end

endmodule

// File: rtl/pmem_ctrl.sv
module pmem_ctrl
   import pmem_pkg::*;
#(
   parameter int AW     = 15,
   parameter int DW     = 8,
   parameter int COL_W  = 3,
   parameter int T_ACC  = 3,
   parameter int T_PC   = 2,
   parameter int T_WP   = 2,
   parameter int T_DS   = 1,
   parameter int T_IDLE = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          close_row,
   output logic          ready,
   output logic          rvalid,
   output logic [DW-1:0] rdata,
   output logic          mem_ce_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_i
);

   localparam int ROW_W  = AW - COL_W;
   localparam int T_WLOW = max3(T_ACC, T_WP, T_DS);
   localparam int T_MAX  = max3(T_ACC, T_WLOW, T_PC);
   localparam int CNT_W  = $clog2(T_MAX + 1) + 1;

   initial begin
      assert (T_ACC >= 1 && T_PC >= 1 && T_WP >= 1 && T_DS >= 0)
         else $error("pmem_ctrl: timing counts out of range");
      assert (AW > COL_W && COL_W >= 1 && DW >= 1)
         else $error("pmem_ctrl: address or data width out of range");
      assert (T_IDLE >= 0)
         else $error("pmem_ctrl: idle timeout must not be negative");
   end

   pm_state_t     state;
   logic          pend;
   logic          p_we;
   logic [AW-1:0] p_addr;

   logic          accept;
   logic          hit, row_open, timeout;
   logic          go_page, go_close;
   logic          launch_now, launch_we;
   logic [AW-1:0] launch_addr;
   logic          tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;

   assign ready  = (state == ST_IDLE) || (state == ST_HOLD);
   assign accept = req && ready;

   assign go_page  = (state == ST_HOLD) && accept && hit && !close_row;
   assign go_close = (state == ST_HOLD) &&
                     ((accept && !go_page) || (!req && (close_row || timeout)));

   always_comb begin
      launch_now  = 1'b0;
      launch_we   = req_we;
      launch_addr = req_addr;
      if ((state == ST_IDLE && accept) || go_page) begin
         launch_now = 1'b1;
      end else if (state == ST_PRE && tmr_done && pend) begin
         launch_now  = 1'b1;
         launch_we   = p_we;
         launch_addr = p_addr;
      end
   end

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (launch_now && !launch_we) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(T_ACC - 1);
      end else if (state == ST_WSET) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(T_WLOW - 1);
      end else if (go_close) begin
         tmr_load = 1'b1;
         tmr_val  = CNT_W'(T_PC - 1);
      end
   end

   pmem_timer #(.W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   pmem_row_tracker #(.ROW_W(ROW_W), .T_IDLE(T_IDLE)) u_rows (
      .clk         (clk),
      .rst_n       (rst_n),
      .open_set    (launch_now),
      .open_row_in (launch_addr[AW-1:COL_W]),
      .close       (go_close),
      .hold_idle   ((state == ST_HOLD) && !req),
      .chk_row     (req_addr[AW-1:COL_W]),
      .row_open    (row_open),
      .hit         (hit),
      .timeout     (timeout)
   );

   pmem_wdata_reg #(.DW(DW)) u_wdata (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (accept && req_we),
      .d     (req_wdata),
      .q     (mem_dq_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_we   <= 1'b0;
         p_addr <= '0;
      end else if (accept) begin
         p_we   <= req_we;
         p_addr <= req_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         pend      <= 1'b0;
         mem_ce_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
         mem_addr  <= '0;
         rvalid    <= 1'b0;
         rdata     <= '0;
      end else begin
         rvalid <= 1'b0;
         if (launch_now) begin
            mem_ce_n <= 1'b0;
            mem_addr <= launch_addr;
            pend     <= 1'b0;
            if (launch_we) begin
               mem_dq_oe <= 1'b1;
               state     <= ST_WSET;
            end else begin
               mem_oe_n <= 1'b0;
               state    <= ST_RD;
            end
         end else begin
            case (state)
               ST_PRE: begin
                  if (tmr_done)
                     state <= ST_IDLE;
               end
               ST_RD: begin
                  if (tmr_done) begin
                     rdata    <= mem_dq_i;
                     rvalid   <= 1'b1;
                     mem_oe_n <= 1'b1;
                     state    <= ST_HOLD;
                  end
               end
               ST_WSET: begin
                  mem_we_n <= 1'b0;
                  state    <= ST_WLOW;
               end
               ST_WLOW: begin
                  if (tmr_done) begin
                     mem_we_n  <= 1'b1;
                     mem_dq_oe <= 1'b0;
                     state     <= ST_HOLD;
                  end
               end
               ST_HOLD: begin
                  if (go_close) begin
                     mem_ce_n <= 1'b1;
                     pend     <= accept;
                     state    <= ST_PRE;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // Assertion support: cycles chip enable has been high, saturating
   logic [CNT_W-1:0] hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hi_cnt <= CNT_W'(T_PC);
      else if (!mem_ce_n)
         hi_cnt <= '0;
      else if (hi_cnt != CNT_W'(T_PC))
         hi_cnt <= hi_cnt + 1'b1;
   end

   // R5: precharge interval honoured before every new activation
   p_precharge_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_ce_n) |-> (hi_cnt == CNT_W'(T_PC)));

   // R6: no output enable while writing or driving the pad
   p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_dq_oe));

   // R3: write pulse lies inside an active chip enable with stable data
   p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && mem_dq_oe));
   p_we_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_o) && $stable(mem_addr)));

   // R2: read result is a single-cycle pulse
   p_rvalid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid |=> !rvalid);

   // R10: one request per handshake
   p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready) |=> !ready);

   // R4: a same-row request keeps chip enable low
   p_page_keep_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ready && hit && !close_row && !mem_ce_n) |=> !mem_ce_n);

endmodule

// File: tb/tb_pmem_ctrl.sv
module tb_pmem_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int T_ACC  = 3;
   localparam int T_PC   = 2;
   localparam int T_WP   = 2;
   localparam int T_DS   = 1;
   localparam int T_IDLE = 16;
   localparam int T_WLOW = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, req_we = 1'b0, close_row = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ready, rvalid;
   logic [7:0]  rdata;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [14:0] mem_addr;
   logic [7:0]  mem_dq_o, mem_dq_i;

   always #(CLK_PERIOD/2) clk = ~clk;

   pmem_ctrl #(.T_ACC(T_ACC), .T_PC(T_PC), .T_WP(T_WP), .T_DS(T_DS),
               .T_IDLE(T_IDLE)) dut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .close_row(close_row),
      .ready(ready), .rvalid(rvalid), .rdata(rdata),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(mem_dq_i)
   );

   int n_cmp = 0, n_bad = 0;
   int ce_rise = 0, we_fall = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string rq, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   // Device model: 256 bytes reachable through mk_addr
   logic [7:0] dev [0:255];
   logic [7:0] expm [0:255];
   int   age = 0, we_lo = 0, ce_hi = 100;
   logic prev_ce_n = 1'b1, prev_we_n = 1'b1;
   logic [14:0] prev_addr = '0;
   logic [7:0]  prev_dq = '0;

   assign mem_dq_i = (!mem_ce_n && !mem_oe_n && mem_we_n && age >= T_ACC - 1)
                     ? dev[mem_addr[7:0]] : ~dev[mem_addr[7:0]];

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_ce_n || mem_addr != prev_addr || prev_ce_n) age = 0;
         else age = age + 1;
         if (!prev_ce_n && mem_ce_n) ce_rise++;
         if (mem_ce_n) ce_hi++;
         else begin
            if (prev_ce_n) check(ce_hi >= T_PC, "R5 precharge", ce_hi, T_PC);
            ce_hi = 0;
         end
         if (!mem_we_n) begin
            we_lo++;
            if (prev_we_n) begin
               we_fall++;
            end else begin
               check(mem_dq_o == prev_dq && mem_addr == prev_addr,
                     "R3 stable", mem_dq_o, prev_dq);
            end
            check(mem_dq_oe && !mem_ce_n, "R3 drive", mem_dq_oe, 1);
         end
         if (!prev_we_n && mem_we_n) begin
            check(we_lo >= T_WLOW, "R3 pulse", we_lo, T_WLOW);
            check(!mem_ce_n, "R3 ce", mem_ce_n, 0);
            dev[mem_addr[7:0]] = mem_dq_o;
            we_lo = 0;
         end
         if (!mem_oe_n && (!mem_we_n || mem_dq_oe))
            check(0, "R6 contention", {mem_we_n, mem_dq_oe}, 2);
      end
      prev_ce_n = mem_ce_n;
      prev_we_n = mem_we_n;
      prev_addr = mem_addr;
      prev_dq   = mem_dq_o;
   end

   function automatic logic [14:0] mk_addr(input logic [7:0] idx);
      logic [6:0] hi;
      hi = {2'b10, idx[7:3]} ^ 7'h2A;
      return {hi, idx};
   endfunction

   task automatic do_req(input bit w, input logic [7:0] idx, input logic [7:0] d,
                         input bit cls);
      int t;
      t = 0;
      @(negedge clk);
      while (!ready && t < 200) begin @(negedge clk); t++; end
      req = 1'b1; req_we = w; req_addr = mk_addr(idx); req_wdata = d; close_row = cls;
      @(negedge clk);
      req = 1'b0; close_row = 1'b0;
      check(ready == 1'b0, "R10 ready", ready, 0);
      if (w) begin
         expm[idx] = d;
      end else begin
         t = 0;
         while (!rvalid && t < 200) begin @(negedge clk); t++; end
         check(rvalid && rdata == expm[idx], "R2 read", rdata, expm[idx]);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!finished) begin
         check(0, "watchdog", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int r0, w0;
      logic [7:0] idx;
      for (int i = 0; i < 256; i++) begin
         dev[i]  = 8'(i) ^ 8'h5A;
         expm[i] = 8'(i) ^ 8'h5A;
      end
      void'($urandom(32'h00C0FFEE));
      wait_n(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(mem_ce_n && mem_we_n && mem_oe_n, "R1 pins", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
      check(!mem_dq_oe, "R1 dq_oe", mem_dq_oe, 0);
      check(ready && !rvalid, "R1 handshake", {ready, rvalid}, 2);

      // R4 page reads and writes in one row
      do_req(0, 8'h10, 8'h00, 0);
      r0 = ce_rise; w0 = we_fall;
      do_req(0, 8'h13, 8'h00, 0);
      do_req(1, 8'h15, 8'hA7, 0);
      do_req(0, 8'h15, 8'h00, 0);
      check(ce_rise == r0, "R4 no ce rise", ce_rise - r0, 0);
      check(we_fall == w0 + 1, "R3 one pulse", we_fall - w0, 1);
      // R7 back-to-back page writes
      do_req(1, 8'h16, 8'h3C, 0);
      do_req(1, 8'h17, 8'hC3, 0);
      do_req(0, 8'h16, 8'h00, 0);
      do_req(0, 8'h17, 8'h00, 0);
      check(we_fall == w0 + 3, "R7 pulses", we_fall - w0, 3);
      check(ce_rise == r0, "R4 page writes", ce_rise - r0, 0);

      // R5 row change
      r0 = ce_rise;
      do_req(0, 8'h40, 8'h00, 0);
      check(ce_rise == r0 + 1, "R5 row change", ce_rise - r0, 1);
      do_req(1, 8'h88, 8'h99, 0);
      do_req(0, 8'h88, 8'h00, 0);

      // R8 idle timeout
      do_req(0, 8'h41, 8'h00, 0);
      wait_n(T_IDLE - 2);
      check(mem_ce_n == 1'b0, "R8 still open", mem_ce_n, 0);
      wait_n(6);
      check(mem_ce_n == 1'b1, "R8 closed", mem_ce_n, 1);

      // R9 explicit close
      do_req(0, 8'h20, 8'h00, 0);
      close_row = 1'b1;
      @(negedge clk);
      close_row = 1'b0;
      wait_n(2);
      check(mem_ce_n == 1'b1, "R9 close", mem_ce_n, 1);
      do_req(0, 8'h22, 8'h00, 0);
      r0 = ce_rise;
      do_req(0, 8'h23, 8'h00, 1);
      check(ce_rise == r0 + 1, "R9 close with req", ce_rise - r0, 1);

      // Random mix
      idx = 8'h00;
      for (int n = 0; n < 500; n++) begin
         int sel;
         sel = int'($urandom_range(0, 99));
         if (sel < 55) idx = {idx[7:3], 3'($urandom_range(0, 7))};
         else idx = 8'($urandom_range(0, 255));
         if (sel >= 95) wait_n(int'($urandom_range(1, 20)));
         do_req(bit'($urandom_range(0, 1)), idx, 8'($urandom_range(0, 255)),
                sel == 50);
      end
      for (int i = 0; i < 256; i += 9) do_req(0, 8'(i), 8'h00, 0);

      wait_n(10);
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule